// File: doc/BRIEF.md
# Two-Path Completion Reorderer with ID Substitution

This block sits between an application master and two downstream paths. One path is cacheable and always completes in order. The other is a direct IO path whose latency differs from the first. Reads and writes arrive on one request channel. The block assigns each accepted request a slot in an eight-entry tag pool and forwards the request with the slot number in place of the application's ID. Bit 1 of the request's cache attribute selects the path.

Completions come back tagged with the slot number, from either path and in any order. The block records each completion in its slot. It then hands read data and write responses back to the application one at a time, strictly in acceptance order, each with the application's original ID restored. When all slots are in use, new requests stall.

A `BYPASS` parameter removes the pool. IDs then travel downstream unchanged, and completions are passed straight through to the application as they arrive. The IO path wins when both paths offer the same kind of completion.

Top module: `axi_reorder_unit`

## Requirements
- R1: Each accepted request is forwarded with a tag that is not held by any other outstanding request.
- R2: A request with `up_req_cache[1]`=0 goes only to the IO path and one with `up_req_cache[1]`=1 goes only to the cacheable path. The request is accepted only when the chosen path is ready.
- R3: Completions are released to the application in the order their requests were accepted, whichever path finishes first. Nothing is released while the oldest request is still pending.
- R4: Reads and writes share a single ordering. A write response waits behind an older read, and a read waits behind an older write.
- R5: Each released read or write response carries the ID that arrived with its request, together with that completion's data and response code.
- R6: While eight requests are outstanding, `up_req_ready` is 0 and neither downstream path sees a valid request. The pool accepts requests again once a release has taken place.
- R7: A released response stays valid with stable ID, data and response code until the application takes it. A handshake frees its slot.
- R8: With `BYPASS`=1, the downstream tag equals the request ID, and a completion appears on the application channel in the same cycle with its tag as the ID.
- R9: After reset, no response is valid and a request to a ready path is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req_valid | input | 1 | Application request valid |
| up_req_ready | output | 1 | Application request accepted |
| up_req_write | input | 1 | 1 = write, 0 = read |
| up_req_id | input | ID_W | Application ID |
| up_req_addr | input | ADDR_W | Address |
| up_req_cache | input | 4 | Cache attribute; bit 1 = cacheable |
| up_req_wdata | input | DATA_W | Write data |
| cc_req_valid | output | 1 | Cacheable path request valid |
| cc_req_ready | input | 1 | Cacheable path ready |
| cc_req_write | output | 1 | Request kind |
| cc_req_tag | output | ID_W | Substituted tag |
| cc_req_addr | output | ADDR_W | Address |
| cc_req_wdata | output | DATA_W | Write data |
| io_req_valid | output | 1 | IO path request valid |
| io_req_ready | input | 1 | IO path ready |
| io_req_write | output | 1 | Request kind |
| io_req_tag | output | ID_W | Substituted tag |
| io_req_addr | output | ADDR_W | Address |
| io_req_wdata | output | DATA_W | Write data |
| cc_cpl_valid | input | 1 | Cacheable completion valid |
| cc_cpl_ready | output | 1 | Cacheable completion accepted |
| cc_cpl_write | input | 1 | Completion kind (used in bypass) |
| cc_cpl_tag | input | ID_W | Completion tag |
| cc_cpl_data | input | DATA_W | Read data |
| cc_cpl_resp | input | 2 | Response code |
| io_cpl_valid | input | 1 | IO completion valid |
| io_cpl_ready | output | 1 | IO completion accepted |
| io_cpl_write | input | 1 | Completion kind (used in bypass) |
| io_cpl_tag | input | ID_W | Completion tag |
| io_cpl_data | input | DATA_W | Read data |
| io_cpl_resp | input | 2 | Response code |
| up_rd_valid | output | 1 | Read data valid |
| up_rd_ready | input | 1 | Application takes read data |
| up_rd_id | output | ID_W | Original ID |
| up_rd_data | output | DATA_W | Read data |
| up_rd_resp | output | 2 | Read response code |
| up_wr_valid | output | 1 | Write response valid |
| up_wr_ready | input | 1 | Application takes write response |
| up_wr_id | output | ID_W | Original ID |
| up_wr_resp | output | 2 | Write response code |

## Verification
The bench lets a younger cacheable read finish before an older IO read. It also lets a younger read finish before an older write. A design that releases completions as they arrive would return the wrong ID first, or show a write response while a read was still owed. The bench fills all eight slots and then checks that a ninth request is held off. An off-by-one in the occupancy count would either accept the ninth request and reuse a live tag, or stall one request too early. The bench also holds `up_rd_ready` low and checks that the pending response stays unchanged, which a head pointer that advanced without a handshake would violate. A second instance built with `BYPASS`=1 checks that IDs pass through unchanged and that completions appear in the same cycle.

// File: rtl/axi_reorder_pkg.sv
package axi_reorder_pkg;
  localparam int CACHE_W   = 4;
  localparam int CACHE_MOD = 1;  // bit that marks a request cacheable
  localparam int RESP_W    = 2;

  function automatic logic is_cacheable(input logic [CACHE_W-1:0] attr);
    return attr[CACHE_MOD];
  endfunction
endpackage

// File: rtl/reorder_router.sv
module reorder_router (
  input  logic up_valid,
  input  logic cacheable,
  input  logic slot_free,
  input  logic cc_ready,
  input  logic io_ready,
  output logic cc_valid,
  output logic io_valid,
  output logic up_ready
);
  always_comb begin
    cc_valid = up_valid && slot_free && cacheable;
    io_valid = up_valid && slot_free && !cacheable;
    up_ready = slot_free && (cacheable ? cc_ready : io_ready);
  end
endmodule

// File: rtl/reorder_tag_ring.sv
module reorder_tag_ring
  import axi_reorder_pkg::*;
#(
  parameter int TAGS   = 8,
  parameter int ID_W   = 4,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(TAGS),
  localparam int CNT_W = $clog2(TAGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [ID_W-1:0]   alloc_id,
  input  logic              alloc_wr,
  output logic [TAG_W-1:0]  alloc_tag,
  output logic              slot_free,
  input  logic              cc_hit,
  input  logic [TAG_W-1:0]  cc_tag,
  input  logic [DATA_W-1:0] cc_data,
  input  logic [RESP_W-1:0] cc_resp,
  input  logic              io_hit,
  input  logic [TAG_W-1:0]  io_tag,
  input  logic [DATA_W-1:0] io_data,
  input  logic [RESP_W-1:0] io_resp,
  input  logic              rd_ready,
  input  logic              wr_ready,
  output logic              rd_valid,
  output logic [ID_W-1:0]   rd_id,
  output logic [DATA_W-1:0] rd_data,
  output logic [RESP_W-1:0] rd_resp,
  output logic              wr_valid,
  output logic [ID_W-1:0]   wr_id,
  output logic [RESP_W-1:0] wr_resp
);
  logic [TAG_W-1:0]  head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [TAGS-1:0]   done_q, done_d;
  logic [ID_W-1:0]   id_q   [TAGS];
  logic [TAGS-1:0]   wr_q;
  logic [DATA_W-1:0] data_q [TAGS];
  logic [RESP_W-1:0] resp_q [TAGS];
  logic head_ok, release_go;

  assign alloc_tag = tail_q;
  assign slot_free = (cnt_q != CNT_W'(TAGS));
  assign head_ok   = (cnt_q != '0) && done_q[head_q];

  always_comb begin
    rd_valid   = head_ok && !wr_q[head_q];
    wr_valid   = head_ok &&  wr_q[head_q];
    rd_id      = id_q[head_q];
    wr_id      = id_q[head_q];
    rd_data    = data_q[head_q];
    rd_resp    = resp_q[head_q];
    wr_resp    = resp_q[head_q];
    release_go = (rd_valid && rd_ready) || (wr_valid && wr_ready);
  end

  always_comb begin
    head_d = release_go ? head_q + 1'b1 : head_q;
    tail_d = alloc ? tail_q + 1'b1 : tail_q;
    cnt_d  = cnt_q;
    if (alloc && !release_go) cnt_d = cnt_q + 1'b1;
    else if (!alloc && release_go) cnt_d = cnt_q - 1'b1;
    for (int i = 0; i < TAGS; i++) begin
      done_d[i] = done_q[i];
      if (cc_hit && cc_tag == TAG_W'(i)) done_d[i] = 1'b1;
      if (io_hit && io_tag == TAG_W'(i)) done_d[i] = 1'b1;
      if (release_go && head_q == TAG_W'(i)) done_d[i] = 1'b0;
      if (alloc && tail_q == TAG_W'(i)) done_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      done_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  for (genvar g = 0; g < TAGS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (alloc && tail_q == TAG_W'(g)) begin
        id_q[g] <= alloc_id;
        wr_q[g] <= alloc_wr;
      end
      if (io_hit && io_tag == TAG_W'(g)) begin
        data_q[g] <= io_data;
        resp_q[g] <= io_resp;
      end else if (cc_hit && cc_tag == TAG_W'(g)) begin
        data_q[g] <= cc_data;
        resp_q[g] <= cc_resp;
      end
    end
  end
endmodule

// File: rtl/reorder_bypass.sv
module reorder_bypass
  import axi_reorder_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int DATA_W = 32
) (
  input  logic              cc_valid,
  input  logic              cc_write,
  input  logic [ID_W-1:0]   cc_tag,
  input  logic [DATA_W-1:0] cc_data,
  input  logic [RESP_W-1:0] cc_resp,
  output logic              cc_ready,
  input  logic              io_valid,
  input  logic              io_write,
  input  logic [ID_W-1:0]   io_tag,
  input  logic [DATA_W-1:0] io_data,
  input  logic [RESP_W-1:0] io_resp,
  output logic              io_ready,
  input  logic              rd_ready,
  input  logic              wr_ready,
  output logic              rd_valid,
  output logic [ID_W-1:0]   rd_id,
  output logic [DATA_W-1:0] rd_data,
  output logic [RESP_W-1:0] rd_resp,
  output logic              wr_valid,
  output logic [ID_W-1:0]   wr_id,
  output logic [RESP_W-1:0] wr_resp
);
  logic io_r, io_w, cc_r, cc_w;
  always_comb begin
    io_r     = io_valid && !io_write;
    io_w     = io_valid &&  io_write;
    cc_r     = cc_valid && !cc_write;
    cc_w     = cc_valid &&  cc_write;
    rd_valid = io_r || cc_r;
    rd_id    = io_r ? io_tag  : cc_tag;
    rd_data  = io_r ? io_data : cc_data;
    rd_resp  = io_r ? io_resp : cc_resp;
    wr_valid = io_w || cc_w;
    wr_id    = io_w ? io_tag  : cc_tag;
    wr_resp  = io_w ? io_resp : cc_resp;
    io_ready = io_write ? wr_ready : rd_ready;
    cc_ready = cc_write ? (wr_ready && !io_w) : (rd_ready && !io_r);
  end
endmodule

// File: rtl/axi_reorder_unit.sv
module axi_reorder_unit
  import axi_reorder_pkg::*;
#(
  parameter int  TAGS   = 8,
  parameter int  ID_W   = 4,
  parameter int  ADDR_W = 16,
  parameter int  DATA_W = 32,
  parameter bit  BYPASS = 1'b0,
  localparam int TAG_W  = $clog2(TAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req_valid,
  output logic              up_req_ready,
  input  logic              up_req_write,
  input  logic [ID_W-1:0]   up_req_id,
  input  logic [ADDR_W-1:0] up_req_addr,
  input  logic [3:0]        up_req_cache,
  input  logic [DATA_W-1:0] up_req_wdata,
  output logic              cc_req_valid,
  input  logic              cc_req_ready,
  output logic              cc_req_write,
  output logic [ID_W-1:0]   cc_req_tag,
  output logic [ADDR_W-1:0] cc_req_addr,
  output logic [DATA_W-1:0] cc_req_wdata,
  output logic              io_req_valid,
  input  logic              io_req_ready,
  output logic              io_req_write,
  output logic [ID_W-1:0]   io_req_tag,
  output logic [ADDR_W-1:0] io_req_addr,
  output logic [DATA_W-1:0] io_req_wdata,
  input  logic              cc_cpl_valid,
  output logic              cc_cpl_ready,
  input  logic              cc_cpl_write,
  input  logic [ID_W-1:0]   cc_cpl_tag,
  input  logic [DATA_W-1:0] cc_cpl_data,
  input  logic [1:0]        cc_cpl_resp,
  input  logic              io_cpl_valid,
  output logic              io_cpl_ready,
  input  logic              io_cpl_write,
  input  logic [ID_W-1:0]   io_cpl_tag,
  input  logic [DATA_W-1:0] io_cpl_data,
  input  logic [1:0]        io_cpl_resp,
  output logic              up_rd_valid,
  input  logic              up_rd_ready,
  output logic [ID_W-1:0]   up_rd_id,
  output logic [DATA_W-1:0] up_rd_data,
  output logic [1:0]        up_rd_resp,
  output logic              up_wr_valid,
  input  logic              up_wr_ready,
  output logic [ID_W-1:0]   up_wr_id,
  output logic [1:0]        up_wr_resp
);
  logic            slot_free;
  logic [ID_W-1:0] fwd_tag;
  logic            accept;
  logic            unused_bits;

  reorder_router u_route (
    .up_valid  (up_req_valid),
    .cacheable (is_cacheable(up_req_cache)),
    .slot_free (slot_free),
    .cc_ready  (cc_req_ready),
    .io_ready  (io_req_ready),
    .cc_valid  (cc_req_valid),
    .io_valid  (io_req_valid),
    .up_ready  (up_req_ready)
  );

  assign accept       = up_req_valid && up_req_ready;
  assign cc_req_write = up_req_write;
  assign io_req_write = up_req_write;
  assign cc_req_addr  = up_req_addr;
  assign io_req_addr  = up_req_addr;
  assign cc_req_wdata = up_req_wdata;
  assign io_req_wdata = up_req_wdata;
  assign cc_req_tag   = fwd_tag;
  assign io_req_tag   = fwd_tag;

  if (BYPASS) begin : g_pass
    assign slot_free   = 1'b1;
    assign fwd_tag     = up_req_id;
    assign unused_bits = ^{accept, up_req_cache};
    reorder_bypass #(.ID_W(ID_W), .DATA_W(DATA_W)) u_pass (
      .cc_valid (cc_cpl_valid), .cc_write (cc_cpl_write), .cc_tag (cc_cpl_tag),
      .cc_data  (cc_cpl_data),  .cc_resp  (cc_cpl_resp),  .cc_ready (cc_cpl_ready),
      .io_valid (io_cpl_valid), .io_write (io_cpl_write), .io_tag (io_cpl_tag),
      .io_data  (io_cpl_data),  .io_resp  (io_cpl_resp),  .io_ready (io_cpl_ready),
      .rd_ready (up_rd_ready),  .wr_ready (up_wr_ready),
      .rd_valid (up_rd_valid),  .rd_id    (up_rd_id),     .rd_data  (up_rd_data),
      .rd_resp  (up_rd_resp),   .wr_valid (up_wr_valid),  .wr_id    (up_wr_id),
      .wr_resp  (up_wr_resp)
    );
  end else begin : g_order
    logic [TAG_W-1:0] ring_tag;
    assign fwd_tag      = ID_W'(ring_tag);
    assign cc_cpl_ready = 1'b1;
    assign io_cpl_ready = 1'b1;
    assign unused_bits  = ^{cc_cpl_write, io_cpl_write, cc_cpl_tag, io_cpl_tag, up_req_cache};
    reorder_tag_ring #(.TAGS(TAGS), .ID_W(ID_W), .DATA_W(DATA_W)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc     (accept),
      .alloc_id  (up_req_id),
      .alloc_wr  (up_req_write),
      .alloc_tag (ring_tag),
      .slot_free (slot_free),
      .cc_hit    (cc_cpl_valid),
      .cc_tag    (cc_cpl_tag[TAG_W-1:0]),
      .cc_data   (cc_cpl_data),
      .cc_resp   (cc_cpl_resp),
      .io_hit    (io_cpl_valid),
      .io_tag    (io_cpl_tag[TAG_W-1:0]),
      .io_data   (io_cpl_data),
      .io_resp   (io_cpl_resp),
      .rd_ready  (up_rd_ready),
      .wr_ready  (up_wr_ready),
      .rd_valid  (up_rd_valid),
      .rd_id     (up_rd_id),
      .rd_data   (up_rd_data),
      .rd_resp   (up_rd_resp),
      .wr_valid  (up_wr_valid),
      .wr_id     (up_wr_id),
      .wr_resp   (up_wr_resp)
    );
  end
endmodule

// File: rtl/axi_reorder_chk.sv
module axi_reorder_chk #(
  parameter int ID_W   = 4,
  parameter int DATA_W = 32,
  parameter int TAGS   = 8,
  parameter bit BYPASS = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_req_valid,
  input logic              up_req_ready,
  input logic              cc_req_valid,
  input logic              io_req_valid,
  input logic              up_rd_valid,
  input logic              up_rd_ready,
  input logic [ID_W-1:0]   up_rd_id,
  input logic [DATA_W-1:0] up_rd_data,
  input logic              up_wr_valid,
  input logic              up_wr_ready,
  input logic [ID_W-1:0]   up_wr_id
);
  localparam int CW = $clog2(TAGS + 2);
  logic [CW-1:0] outstanding;
  logic acc, rel;
  assign acc = up_req_valid && up_req_ready;
  assign rel = (up_rd_valid && up_rd_ready) || (up_wr_valid && up_wr_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outstanding <= '0;
    else if (acc && !rel) outstanding <= outstanding + 1'b1;
    else if (!acc && rel) outstanding <= outstanding - 1'b1;
  end

  assert_route_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cc_req_valid && io_req_valid));

  if (!BYPASS) begin : g_ord_chk
    assert_stall_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (outstanding == CW'(TAGS)) |-> (!up_req_ready && !cc_req_valid && !io_req_valid));
    assert_single_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(up_rd_valid && up_wr_valid));
    assert_no_release_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (outstanding == '0) |-> (!up_rd_valid && !up_wr_valid));
    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (up_rd_valid && !up_rd_ready) |=> (up_rd_valid && $stable(up_rd_id) && $stable(up_rd_data)));
    assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (up_wr_valid && !up_wr_ready) |=> (up_wr_valid && $stable(up_wr_id)));
  end
endmodule

bind axi_reorder_unit axi_reorder_chk #(
  .ID_W(ID_W), .DATA_W(DATA_W), .TAGS(TAGS), .BYPASS(BYPASS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .up_req_valid(up_req_valid), .up_req_ready(up_req_ready),
  .cc_req_valid(cc_req_valid), .io_req_valid(io_req_valid),
  .up_rd_valid(up_rd_valid), .up_rd_ready(up_rd_ready), .up_rd_id(up_rd_id),
  .up_rd_data(up_rd_data), .up_wr_valid(up_wr_valid), .up_wr_ready(up_wr_ready),
  .up_wr_id(up_wr_id)
);

// File: tb/axi_reorder_unit_tb_top.sv
module axi_reorder_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  logic        up_req_valid = 0, up_req_write = 0;
  logic [3:0]  up_req_id = 0, up_req_cache = 0;
  logic [15:0] up_req_addr = 0;
  logic [31:0] up_req_wdata = 0;
  logic        cc_req_ready = 1, io_req_ready = 1;
  logic        cc_cpl_valid = 0, cc_cpl_write = 0, io_cpl_valid = 0, io_cpl_write = 0;
  logic [3:0]  cc_cpl_tag = 0, io_cpl_tag = 0;
  logic [31:0] cc_cpl_data = 0, io_cpl_data = 0;
  logic [1:0]  cc_cpl_resp = 0, io_cpl_resp = 0;
  logic        up_rd_ready = 0, up_wr_ready = 0;
  logic        up_req_ready, cc_req_valid, cc_req_write, io_req_valid, io_req_write;
  logic [3:0]  cc_req_tag, io_req_tag, up_rd_id, up_wr_id;
  logic [15:0] cc_req_addr, io_req_addr;
  logic [31:0] cc_req_wdata, io_req_wdata, up_rd_data;
  logic        cc_cpl_ready, io_cpl_ready, up_rd_valid, up_wr_valid;
  logic [1:0]  up_rd_resp, up_wr_resp;

  axi_reorder_unit dut_i (.*);

  // bypass instance
  logic        b_req_ready, b_cc_valid, b_io_valid, b_cc_write, b_io_write;
  logic [3:0]  b_cc_tag, b_io_tag, b_rd_id, b_wr_id;
  logic [15:0] b_cc_addr, b_io_addr;
  logic [31:0] b_cc_wdata, b_io_wdata, b_rd_data;
  logic        b_cc_cpl_ready, b_io_cpl_ready, b_rd_valid, b_wr_valid;
  logic [1:0]  b_rd_resp, b_wr_resp;

  axi_reorder_unit #(.BYPASS(1'b1)) dut_byp_i (
    .clk(clk), .rst_n(rst_n),
    .up_req_valid(up_req_valid), .up_req_ready(b_req_ready), .up_req_write(up_req_write),
    .up_req_id(up_req_id), .up_req_addr(up_req_addr), .up_req_cache(up_req_cache),
    .up_req_wdata(up_req_wdata),
    .cc_req_valid(b_cc_valid), .cc_req_ready(cc_req_ready), .cc_req_write(b_cc_write),
    .cc_req_tag(b_cc_tag), .cc_req_addr(b_cc_addr), .cc_req_wdata(b_cc_wdata),
    .io_req_valid(b_io_valid), .io_req_ready(io_req_ready), .io_req_write(b_io_write),
    .io_req_tag(b_io_tag), .io_req_addr(b_io_addr), .io_req_wdata(b_io_wdata),
    .cc_cpl_valid(cc_cpl_valid), .cc_cpl_ready(b_cc_cpl_ready), .cc_cpl_write(cc_cpl_write),
    .cc_cpl_tag(cc_cpl_tag), .cc_cpl_data(cc_cpl_data), .cc_cpl_resp(cc_cpl_resp),
    .io_cpl_valid(io_cpl_valid), .io_cpl_ready(b_io_cpl_ready), .io_cpl_write(io_cpl_write),
    .io_cpl_tag(io_cpl_tag), .io_cpl_data(io_cpl_data), .io_cpl_resp(io_cpl_resp),
    .up_rd_valid(b_rd_valid), .up_rd_ready(up_rd_ready), .up_rd_id(b_rd_id),
    .up_rd_data(b_rd_data), .up_rd_resp(b_rd_resp),
    .up_wr_valid(b_wr_valid), .up_wr_ready(up_wr_ready), .up_wr_id(b_wr_id),
    .up_wr_resp(b_wr_resp)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // present a request at the negedge, check routing, accept at the posedge
  task automatic issue(input bit wr, input logic [3:0] id, input bit cacheable, output logic [3:0] tag);
    @(negedge clk);
    up_req_valid = 1; up_req_write = wr; up_req_id = id;
    up_req_cache = cacheable ? 4'b0010 : 4'b0000;
    up_req_addr = {12'h0, id}; up_req_wdata = {28'h0, id};
    #1;
    check(up_req_ready, "R9/R2 accept", up_req_ready, 1);
    check(cacheable ? (cc_req_valid && !io_req_valid) : (io_req_valid && !cc_req_valid),
          "R2 route", {cc_req_valid, io_req_valid}, cacheable ? 2 : 1);
    tag = cacheable ? cc_req_tag : io_req_tag;
    @(posedge clk); #1;
    up_req_valid = 0;
  endtask

  task automatic complete(input bit io, input bit wr, input logic [3:0] tag,
                          input logic [31:0] data, input logic [1:0] resp);
    @(negedge clk);
    if (io) begin io_cpl_valid = 1; io_cpl_write = wr; io_cpl_tag = tag; io_cpl_data = data; io_cpl_resp = resp; end
    else    begin cc_cpl_valid = 1; cc_cpl_write = wr; cc_cpl_tag = tag; cc_cpl_data = data; cc_cpl_resp = resp; end
    @(posedge clk); #1;
    io_cpl_valid = 0; cc_cpl_valid = 0;
  endtask

  task automatic take_rd(input string req, input logic [3:0] id, input logic [31:0] data);
    @(negedge clk);
    check(up_rd_valid && !up_wr_valid, {req, " rd valid"}, {up_rd_valid, up_wr_valid}, 2);
    check(up_rd_id == id, {req, " rd id (R5)"}, up_rd_id, id);
    check(up_rd_data == data, {req, " rd data (R5)"}, up_rd_data, data);
    up_rd_ready = 1;
    @(posedge clk); #1;
    up_rd_ready = 0;
  endtask

  task automatic take_wr(input string req, input logic [3:0] id, input logic [1:0] resp);
    @(negedge clk);
    check(up_wr_valid && !up_rd_valid, {req, " wr valid"}, {up_wr_valid, up_rd_valid}, 2);
    check(up_wr_id == id, {req, " wr id (R5)"}, up_wr_id, id);
    check(up_wr_resp == resp, {req, " wr resp (R5)"}, up_wr_resp, resp);
    up_wr_ready = 1;
    @(posedge clk); #1;
    up_wr_ready = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(!up_rd_valid && !up_wr_valid, "R9 no response after reset", {up_rd_valid, up_wr_valid}, 0);
    check(!b_rd_valid && !b_wr_valid, "R9 bypass idle", {b_rd_valid, b_wr_valid}, 0);
  endtask

  task automatic t_out_of_order_read;
    logic [3:0] ta, tb;
    issue(0, 4'd5, 0, ta);
    issue(0, 4'd9, 1, tb);
    check(ta != tb, "R1 distinct tags", tb, ta + 1);
    complete(0, 0, tb, 32'hBBBB_0009, 2'd0);
    @(negedge clk);
    check(!up_rd_valid, "R3 younger held back", up_rd_valid, 0);
    complete(1, 0, ta, 32'hAAAA_0005, 2'd2);
    take_rd("R3 oldest first", 4'd5, 32'hAAAA_0005);
    take_rd("R3 younger next", 4'd9, 32'hBBBB_0009);
    @(negedge clk);
    check(!up_rd_valid, "R3 drained", up_rd_valid, 0);
  endtask

  task automatic t_mixed_kinds;
    logic [3:0] tw, tr;
    issue(1, 4'd2, 0, tw);
    issue(0, 4'd3, 1, tr);
    complete(0, 0, tr, 32'h1234_5678, 2'd0);
    @(negedge clk);
    check(!up_rd_valid && !up_wr_valid, "R4 read waits behind write", {up_rd_valid, up_wr_valid}, 0);
    complete(1, 1, tw, 32'h0, 2'd1);
    take_wr("R4 write first", 4'd2, 2'd1);
    take_rd("R4 read after", 4'd3, 32'h1234_5678);
  endtask

  task automatic t_hold;
    logic [3:0] t;
    issue(0, 4'd11, 0, t);
    complete(1, 0, t, 32'hCAFE_000B, 2'd3);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(up_rd_valid && up_rd_id == 4'd11 && up_rd_data == 32'hCAFE_000B && up_rd_resp == 2'd3,
            "R7 held while not ready", up_rd_data, 32'hCAFE_000B);
    end
    take_rd("R7 taken", 4'd11, 32'hCAFE_000B);
    @(negedge clk);
    check(!up_rd_valid, "R7 slot freed", up_rd_valid, 0);
  endtask

  task automatic t_full;
    logic [3:0] tags [8];
    for (int i = 0; i < 8; i++) issue(0, 4'(i), 1, tags[i]);
    for (int i = 0; i < 8; i++)
      for (int j = i + 1; j < 8; j++)
        check(tags[i] != tags[j], "R1 tag unique", tags[j], 16'hFFFF);
    @(negedge clk);
    up_req_valid = 1; up_req_cache = 4'b0010; up_req_id = 4'd15;
    #1;
    check(!up_req_ready, "R6 stall when full", up_req_ready, 0);
    check(!cc_req_valid && !io_req_valid, "R6 nothing forwarded", {cc_req_valid, io_req_valid}, 0);
    @(posedge clk); #1;
    up_req_valid = 0;
    for (int i = 0; i < 8; i++) complete(0, 0, tags[i], 32'h5000_0000 + i, 2'd0);
    for (int i = 0; i < 8; i++) take_rd("R6 drain order", 4'(i), 32'h5000_0000 + i);
    @(negedge clk);
    up_req_valid = 1; up_req_cache = 4'b0000;
    #1;
    check(up_req_ready, "R6 accepts again", up_req_ready, 1);
    up_req_valid = 0;
  endtask

  task automatic t_bypass;
    @(negedge clk);
    up_req_valid = 1; up_req_write = 0; up_req_id = 4'd7; up_req_cache = 4'b0000;
    #1;
    check(b_io_valid && b_io_tag == 4'd7, "R8 id passes through", b_io_tag, 7);
    up_req_valid = 0;
    io_cpl_valid = 1; io_cpl_write = 0; io_cpl_tag = 4'd7; io_cpl_data = 32'h7777_7777; io_cpl_resp = 0;
    cc_cpl_valid = 1; cc_cpl_write = 1; cc_cpl_tag = 4'd3; cc_cpl_resp = 2'd1;
    #1;
    check(b_rd_valid && b_rd_id == 4'd7 && b_rd_data == 32'h7777_7777, "R8 read same cycle", b_rd_id, 7);
    check(b_wr_valid && b_wr_id == 4'd3 && b_wr_resp == 2'd1, "R8 write same cycle", b_wr_id, 3);
    io_cpl_valid = 0; cc_cpl_valid = 0;
    // the main instance must ignore these completions: its pool is empty
    @(negedge clk);
    check(!up_rd_valid && !up_wr_valid, "R3 empty pool releases nothing", {up_rd_valid, up_wr_valid}, 0);
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_out_of_order_read();
    t_mixed_kinds();
    t_hold();
    t_full();
    t_bypass();
    repeat (2) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule